// File: doc/BRIEF.md
# ADC Output Test-Pattern Formatter

This block sits between a 12-bit converter sample stream and the output drivers. It decides what appears on the 12 output data bits and on the output clock-enable flag. One 8-bit control byte holds all the settings. A single-cycle write strobe loads the byte, and the current value can always be read back.

The upper two control bits select the data source: the sampled data unchanged, a scrambled form where every upper bit is XORed with the sample's least significant bit, a 7-bit pseudo-random sequence, or a word that alternates between all ones and all zeros. The lowest two bits form a level override. When it is engaged, every output, including the clock-enable flag, is held low or high so that the driver levels can be checked. The override wins over any data mode. The middle four bits are driver-strength and termination codes. They are stored and read back, and they have no effect on the outputs.

Each output is registered, so an accepted sample appears on the outputs exactly one clock later in every mode.

Top module: `adc_pattern_fmt`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x04, `out_data` is 0 and `out_clk_en` is 0.
- R2: A cycle with `cfg_we` high stores `cfg_wdata`, and `cfg_rdata` shows it from the next cycle. A sample presented in the same cycle as a write is still formatted with the old settings. The new settings apply from the next sample.
- R3: With mode bits [7:6] = 00 and no override, a cycle with `smp_valid` high gives `out_data` = `smp_data` and `out_clk_en` = 1 one cycle later. In a cycle without a valid sample, `out_data` keeps its value and `out_clk_en` is 0 one cycle later.
- R4: With mode bits [7:6] = 01, output bit i (for i from 1 to 11) is sample bit i XOR sample bit 0. Output bit 0 equals sample bit 0.
- R5: With mode bits [7:6] = 10, output bit i equals bit (i mod 7) of a 7-bit register S. S is seeded to 7'h7F by reset. After each valid sample in this mode, S becomes {S[5:0], S[6]^S[5]}. S does not change on any other cycle.
- R6: With mode bits [7:6] = 11, every output bit is 1 on the first valid sample after the mode is entered. The value then inverts on each further valid sample. Cycles without a valid sample do not advance the pattern.
- R7: With override bits [1:0] = 10, from the next cycle `out_data` is all zeros and `out_clk_en` is 0, whatever the mode or the sample valid.
- R8: With override bits [1:0] = 11, from the next cycle `out_data` is all ones and `out_clk_en` is 1, whatever the mode or the sample valid.
- R9: Override codes 00 and 01 both select normal operation. Bits [5:2] are read back as written and change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchronizer |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte to store |
| cfg_rdata | output | 8 | Stored control byte |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | 12 | Converter sample |
| out_data | output | 12 | Formatted output word |
| out_clk_en | output | 1 | Output clock enable |

## Verification
In pass mode the stimulus includes walking ones, all ones, all zeros and alternating checkerboards, which expose any stuck or swapped bit lane. Scrambled mode uses samples with bit 0 both clear and set, so a missing XOR or an inverted bit 0 shows up. The pseudo-random and toggle runs insert idle gaps, re-enter the mode, and include a reset partway through. These runs separate per-sample advance from per-clock advance and catch a missing reseed or a missing restart of the toggle phase. The override codes are applied over every data mode, with and without valid samples, to confirm that the override takes priority and also drives the clock-enable flag.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

  localparam int SAMPLE_W = 12;
  localparam int CTRL_W   = 8;
  localparam int PRBS_LEN = 7;
  localparam int PRBS_TAP = 6;

  typedef enum logic [1:0] {
    DM_PASS     = 2'b00,
    DM_SCRAMBLE = 2'b01,
    DM_PRBS     = 2'b10,
    DM_TOGGLE   = 2'b11
  } data_mode_e;

  typedef enum logic [1:0] {
    LV_NORMAL_A = 2'b00,
    LV_NORMAL_B = 2'b01,
    LV_LOW      = 2'b10,
    LV_HIGH     = 2'b11
  } level_ovr_e;

  typedef struct packed {
    data_mode_e mode;   // [7:6]
    logic [1:0] term;   // [5:4] stored only
    logic [1:0] drive;  // [3:2] stored only
    level_ovr_e lvl;    // [1:0]
  } ctrl_t;

  localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h04;

endpackage

// File: rtl/adc_fmt_rst_sync.sv
module adc_fmt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/adc_fmt_ctrl_reg.sv
module adc_fmt_ctrl_reg
  import adc_fmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_byte,
  output ctrl_t             ctrl_q
);

  ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d = ctrl_t'(wr_byte);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= ctrl_t'(CTRL_RESET);
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctrl_q == ctrl_t'($past(wr_byte)))); // R2

  AST_CTRL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q)); // R2

endmodule

// File: rtl/adc_fmt_prbs.sv
module adc_fmt_prbs #(
  parameter int OUT_W = 12,
  parameter int LEN   = 7,
  parameter int TAP   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [OUT_W-1:0] pattern
);

  localparam logic [LEN-1:0] SEED = {LEN{1'b1}};

  logic [LEN-1:0] lfsr_q;
  logic [LEN-1:0] lfsr_d;
  logic           feedback;

  always_comb begin
    feedback = lfsr_q[LEN-1] ^ lfsr_q[TAP-1];
    lfsr_d   = lfsr_q;
    if (step) begin
      lfsr_d = {lfsr_q[LEN-2:0], feedback};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= SEED;
    end else begin
      lfsr_q <= lfsr_d;
    end
  end

  for (genvar gi = 0; gi < OUT_W; gi++) begin : g_fan
    assign pattern[gi] = lfsr_q[gi % LEN];
  end

  AST_PRBS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0); // R5

  AST_PRBS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(lfsr_q)); // R5

  AST_PRBS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (lfsr_q[LEN-1:1] == $past(lfsr_q[LEN-2:0]))); // R5

endmodule

// File: rtl/adc_fmt_toggle.sv
module adc_fmt_toggle #(
  parameter int OUT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  output logic [OUT_W-1:0] pattern
);

  logic ones_q;
  logic ones_d;

  always_comb begin
    ones_d = ones_q;
    if (restart) begin
      ones_d = 1'b1;
    end else if (step) begin
      ones_d = ~ones_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= 1'b1;
    end else begin
      ones_q <= ones_d;
    end
  end

  assign pattern = {OUT_W{ones_q}};

  AST_TOG_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> ones_q); // R6

  AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !restart) |=> (ones_q != $past(ones_q))); // R6

endmodule

// File: rtl/adc_pattern_fmt.sv
module adc_pattern_fmt
  import adc_fmt_pkg::*;
#(
  parameter int DATA_W      = SAMPLE_W,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_wdata,
  output logic [CTRL_W-1:0] cfg_rdata,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  output logic [DATA_W-1:0] out_data,
  output logic              out_clk_en
);

  logic              rst_ns;
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] prbs_word;
  logic [DATA_W-1:0] tog_word;
  logic [DATA_W-1:0] scr_word;
  logic              prbs_step;
  logic              tog_step;
  logic              tog_restart;
  logic [DATA_W-1:0] data_d;
  logic [DATA_W-1:0] data_q;
  logic              ce_d;
  logic              ce_q;

  adc_fmt_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  adc_fmt_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_ns),
    .wr_en   (cfg_we),
    .wr_byte (cfg_wdata),
    .ctrl_q  (ctrl_q)
  );

  assign cfg_rdata   = ctrl_q;
  assign prbs_step   = smp_valid && (ctrl_q.mode == DM_PRBS);
  assign tog_step    = smp_valid && (ctrl_q.mode == DM_TOGGLE);
  assign tog_restart = (ctrl_q.mode != DM_TOGGLE);

  adc_fmt_prbs #(.OUT_W(DATA_W), .LEN(PRBS_LEN), .TAP(PRBS_TAP)) u_prbs (
    .clk     (clk),
    .rst_n   (rst_ns),
    .step    (prbs_step),
    .pattern (prbs_word)
  );

  adc_fmt_toggle #(.OUT_W(DATA_W)) u_tog (
    .clk     (clk),
    .rst_n   (rst_ns),
    .restart (tog_restart),
    .step    (tog_step),
    .pattern (tog_word)
  );

  assign scr_word[0] = smp_data[0];
  for (genvar gi = 1; gi < DATA_W; gi++) begin : g_scr
    assign scr_word[gi] = smp_data[gi] ^ smp_data[0];
  end

  always_comb begin
    data_d = data_q;
    ce_d   = 1'b0;
    case (ctrl_q.lvl)
      LV_LOW: begin
        data_d = '0;
        ce_d   = 1'b0;
      end
      LV_HIGH: begin
        data_d = '1;
        ce_d   = 1'b1;
      end
      default: begin
        if (smp_valid) begin
          ce_d = 1'b1;
          case (ctrl_q.mode)
            DM_PASS:     data_d = smp_data;
            DM_SCRAMBLE: data_d = scr_word;
            DM_PRBS:     data_d = prbs_word;
            default:     data_d = tog_word;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      data_q <= '0;
      ce_q   <= 1'b0;
    end else begin
      data_q <= data_d;
      ce_q   <= ce_d;
    end
  end

  assign out_data   = data_q;
  assign out_clk_en = ce_q;

  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_ns)
    (ctrl_q.lvl == LV_LOW) |=> (out_data == '0 && !out_clk_en)); // R7

  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_ns)
    (ctrl_q.lvl == LV_HIGH) |=> (out_data == '1 && out_clk_en)); // R8

  AST_PASS_DATA: assert property (@(posedge clk) disable iff (!rst_ns)
    (!ctrl_q.lvl[1] && ctrl_q.mode == DM_PASS && smp_valid)
      |=> (out_data == $past(smp_data) && out_clk_en)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_ns)
    (!ctrl_q.lvl[1] && !smp_valid) |=> ($stable(out_data) && !out_clk_en)); // R3

  AST_SCR_LSB: assert property (@(posedge clk) disable iff (!rst_ns)
    (!ctrl_q.lvl[1] && ctrl_q.mode == DM_SCRAMBLE && smp_valid)
      |=> (out_data[0] == $past(smp_data[0]))); // R4

endmodule

// File: tb/adc_pattern_fmt_tb_top.sv
module adc_pattern_fmt_tb_top;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic        smp_valid;
  logic [11:0] smp_data;
  logic [11:0] out_data;
  logic        out_clk_en;

  adc_pattern_fmt dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .smp_valid  (smp_valid),
    .smp_data   (smp_data),
    .out_data   (out_data),
    .out_clk_en (out_clk_en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    logic [11:0] d;
    logic        ce;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  logic [7:0]  m_cfg;
  logic [6:0]  m_lfsr;
  logic        m_tog;
  logic [11:0] m_prev;

  task automatic model_reset();
    m_cfg  = 8'h04;
    m_lfsr = 7'h7F;
    m_tog  = 1'b1;
    m_prev = '0;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [11:0] d,
                      input logic we = 1'b0, input logic [7:0] wd = 8'h00);
    exp_t        e;
    logic [11:0] p;
    @(negedge clk);
    smp_valid = v;
    smp_data  = d;
    cfg_we    = we;
    cfg_wdata = wd;
    e.ce = 1'b0;
    if (m_cfg[1:0] == 2'b10) begin
      e.d = '0; e.ce = 1'b0; e.tag = "R7";
    end else if (m_cfg[1:0] == 2'b11) begin
      e.d = '1; e.ce = 1'b1; e.tag = "R8";
    end else if (v) begin
      e.ce = 1'b1;
      case (m_cfg[7:6])
        2'b00: begin e.d = d; e.tag = "R3"; end
        2'b01: begin e.d = {d[11:1] ^ {11{d[0]}}, d[0]}; e.tag = "R4"; end
        2'b10: begin
          for (int i = 0; i < 12; i++) p[i] = m_lfsr[i % 7];
          e.d = p; e.tag = "R5";
        end
        default: begin e.d = {12{m_tog}}; e.tag = "R6"; end
      endcase
    end else begin
      e.d = m_prev; e.tag = "R3";
    end
    if (m_cfg[1:0] < 2'b10 && (m_cfg[1:0] == 2'b01 || m_cfg[5:2] != 4'b0001))
      e.tag = {e.tag, "/R9"};
    if (we) e.tag = {e.tag, "/R2"};
    m_prev = e.d;
    q.push_back(e);
    if (v && m_cfg[7:6] == 2'b10) m_lfsr = {m_lfsr[5:0], m_lfsr[6] ^ m_lfsr[5]};
    if (m_cfg[7:6] != 2'b11) m_tog = 1'b1;
    else if (v) m_tog = ~m_tog;
    if (we) m_cfg = wd;
  endtask

  task automatic wr(input logic [7:0] b);
    step(1'b0, 12'h000, 1'b1, b);
  endtask

  task automatic do_reset();
    @(negedge clk);
    smp_valid = 0; cfg_we = 0; smp_data = 0; cfg_wdata = 0;
    @(negedge clk);
    @(negedge clk);
    q.delete();
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 out_data in reset", {20'd0, out_data}, 32'd0);
    check("R1 out_clk_en in reset", {31'd0, out_clk_en}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_reset();
    check("R1 cfg_rdata", {24'd0, cfg_rdata}, 32'h04);
    check("R1 out_data", {20'd0, out_data}, 32'd0);
    check("R1 out_clk_en", {31'd0, out_clk_en}, 32'd0);
  endtask

  // monitor: compare each registered result one edge after its sample
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check({e.tag, " out_data"}, {20'd0, out_data}, {20'd0, e.d});
        check({e.tag, " out_clk_en"}, {31'd0, out_clk_en}, {31'd0, e.ce});
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b1; cfg_we = 0; cfg_wdata = 0; smp_valid = 0; smp_data = 0;
    model_reset();
    #1 rst_n = 1'b0;
    do_reset();

    // R3 pass-through with walking ones, extremes, checkerboards, idle gaps
    for (int i = 0; i < 12; i++) step(1'b1, 12'h001 << i);
    step(1'b1, 12'hFFF); step(1'b0, 12'h000); step(1'b1, 12'h000);
    step(1'b1, 12'hA5A); step(1'b0, 12'h3C3); step(1'b0, 12'h111); step(1'b1, 12'h5A5);

    // R2 write with a sample in the same cycle: old mode applies
    step(1'b1, 12'h123, 1'b1, 8'h44);
    step(1'b1, 12'h123);
    check("R2 readback", {24'd0, cfg_rdata}, 32'h44);

    // R4 scrambled, bit 0 clear and set
    step(1'b1, 12'hABC); step(1'b1, 12'hABD); step(1'b1, 12'hFFF);
    step(1'b1, 12'h001); step(1'b0, 12'h777); step(1'b1, 12'h800); step(1'b1, 12'h555);

    // R5 PRBS with gaps
    wr(8'h84);
    for (int i = 0; i < 30; i++) step((i % 4) != 3, 12'h0F0);
    // reseed by reset
    do_reset();
    wr(8'h84);
    for (int i = 0; i < 10; i++) step(1'b1, 12'hFFF);

    // R6 toggle, gaps, leave and re-enter
    wr(8'hC4);
    step(1'b1, 12'h0); step(1'b1, 12'h0); step(1'b0, 12'h0);
    step(1'b1, 12'h0); step(1'b1, 12'h0);
    wr(8'h04);
    step(1'b1, 12'h321);
    wr(8'hC4);
    step(1'b1, 12'h0); step(1'b0, 12'h0); step(1'b1, 12'h0); step(1'b1, 12'h0);

    // R7 / R8 override over each mode, valid and idle
    for (int m = 0; m < 4; m++) begin
      wr({m[1:0], 4'b0001, 2'b10});
      step(1'b1, 12'hF0F); step(1'b0, 12'h0); step(1'b1, 12'h123);
      wr({m[1:0], 4'b0001, 2'b11});
      step(1'b1, 12'h000); step(1'b0, 12'h0); step(1'b1, 12'h456);
    end

    // R9 override 01 and stored-only fields
    wr(8'hF9);
    step(1'b1, 12'h0); step(1'b1, 12'h0); step(1'b1, 12'h0);
    wr(8'h39);
    step(1'b1, 12'h9A6); step(1'b1, 12'h4C3);
    check("R9 readback", {24'd0, cfg_rdata}, 32'h39);
    wr(8'h7C);
    step(1'b1, 12'h9A7); step(1'b1, 12'h002);
    check("R9 readback b", {24'd0, cfg_rdata}, 32'h7C);

    step(1'b0, 12'h0);
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule